// File: doc/BRIEF.md
# Serial Receiver with Framing-Error Flag

This block is the receive side of a byte-oriented asynchronous serial port. It watches an idle-high serial line and counts a bit-rate enable that pulses sixteen times per bit. It recognises a start bit and assembles either eight or nine data bits, least significant first. When a frame is accepted it raises a receive-complete flag and loads a read-only receive buffer in the same cycle. A stop bit that is sampled low sets a sticky framing-error flag.

Software reaches the block through one 8-bit control register and a one-bit view-select option. Bit 7 of the control register is a shared slot. With the view bit clear, it holds the upper mode bit. With the view bit set, reads and writes of that slot reach the framing-error flag instead. The view bit also decides where a 9-bit frame is accepted. With the view bit clear, acceptance happens at the ninth data bit. With it set, acceptance waits for the stop bit. In 9-bit modes, an address-filter enable drops frames whose ninth bit is 0.

Top module: `serial_rx_fe`

## Requirements
- R1: After reset the control register reads 0x00, the view bit reads 0, the receive buffer reads 0x00 and the receiver is idle.
- R2: Control bits are: 7 shared slot, 6 lower mode bit, 5 address-filter enable, 4 receive enable, 3 transmit ninth bit (storage only), 2 received ninth bit, 1 transmit-done (storage only), 0 receive-complete. The mode is {stored bit 7, bit 6}: 00 off, 01 8-bit frames, 10 and 11 9-bit frames. With view=1, bit 7 reads and writes the framing-error flag and the stored mode bit is left unchanged.
- R3: No reception takes place when the receive enable is 0 or the mode is 00. Line activity then leaves the receive-complete flag and the buffer unchanged.
- R4: In 8-bit mode, whatever the view bit, the buffer loads and the receive-complete flag sets at the mid-bit decision of the stop bit. The received ninth bit is left unchanged.
- R5: In 9-bit modes with view=0, the frame is accepted at the mid-bit decision of the ninth bit, and that bit is copied into control bit 2.
- R6: In 9-bit modes with view=1, the frame is accepted at the mid-bit decision of the stop bit.
- R7: Each bit takes the 2-of-3 majority of ticks 7, 8 and 9 of its 16 ticks, so a single deviating sample does not change the received value.
- R8: A falling line edge starts a frame. If the start bit's majority is high, the receiver returns to idle without flagging anything, and the next frame is received normally.
- R9: In every mode, a stop bit whose majority is 0 sets the framing-error flag. A later good stop bit does not clear it. Only a write of 0 through bit 7 with view=1 clears it.
- R10: In 9-bit modes with the address filter on, a frame whose ninth bit is 0 sets no flag and leaves the buffer unchanged. A frame whose ninth bit is 1 is accepted.
- R11: A hardware set of the receive-complete flag or the framing-error flag wins over a software write of 0 in the same cycle.
- R12: Bit timing counts only cycles in which the bit-rate enable is high, so frames are received when the enable pulses once every N clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | Enable pulsing 16 times per bit period |
| rxd | input | 1 | Serial line, idle high, synchronised inside |
| ctrl_we | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 8 | Control register write data |
| opt_we | input | 1 | Write strobe for the view bit |
| opt_wdata | input | 1 | New view bit value |
| ctrl_rdata | output | 8 | Control register read value, bit 7 per view |
| opt_rdata | output | 1 | Current view bit |
| rxbuf_rdata | output | DATA_W | Receive buffer |

## Verification
Hardware flag setting and software register writes can land in the same cycle. The bench provokes this by issuing a control write of 0 to both the receive-complete bit and the framing-error bit on exactly the clock at which a stop bit sampled low is decided. It computes that clock from the synchroniser depth and the 16-tick bit grid. Both flags are required to read 1 afterwards. A later write with no collision must clear them, which shows the write path itself works.

// File: rtl/serrx_pkg.sv
// Shared types and control-register layout for the serial receiver.
// Assumes an 8-bit control register whose bit order is fixed by software.
package serrx_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

    // Control register, MSB first; field order is the software-visible layout.
    typedef struct packed {
        logic top;       // upper mode bit (or framing error via view)
        logic mode_lo;
        logic mp_en;
        logic rx_en;
        logic tx_b9;
        logic rx_b9;
        logic tx_done;
        logic rx_done;
    } ctrl_s;

    localparam int CTRL_W = 8;

endpackage

// File: rtl/serrx_sampler.sv
// Oversampling bit timer. Counts enabled ticks within a bit, captures two
// samples before the decision tick and votes with the third.
// Assumes arm and run are never high together (arm only while idle).
module serrx_sampler #(
    parameter int OVS = 16,
    parameter int MID = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic arm,
    input  logic run,
    input  logic rxd_s,
    output logic decide,
    output logic bit_val,
    output logic bit_end
);
    localparam int CW = $clog2(OVS);

    logic [CW-1:0] cnt;
    logic          smp_a;
    logic          smp_b;

    // Tick counter: the arming tick is sample 0, so the count restarts at 1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (arm)
            cnt <= CW'(1);
        else if (run && tick)
            cnt <= (cnt == CW'(OVS - 1)) ? '0 : cnt + 1'b1;
    end

    // Capture the two samples ahead of the decision tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_a <= 1'b1;
            smp_b <= 1'b1;
        end else if (run && tick) begin
            if (cnt == CW'(MID - 1)) smp_a <= rxd_s;
            if (cnt == CW'(MID))     smp_b <= rxd_s;
        end
    end

    // Majority vote and bit-phase strobes.
    assign bit_val = (smp_a & smp_b) | (smp_a & rxd_s) | (smp_b & rxd_s);
    assign decide  = run && tick && (cnt == CW'(MID + 1));
    assign bit_end = run && tick && (cnt == CW'(OVS - 1));

endmodule

// File: rtl/serrx_frame_fsm.sv
// Frame sequencer: detects the start edge, walks start, data and stop bits,
// and issues acceptance and framing-error events.
// Assumes the sampler supplies one decide and one bit_end strobe per bit.
module serrx_frame_fsm
    import serrx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd_s,
    input  logic [1:0]        mode,
    input  logic              rx_en,
    input  logic              mp_en,
    input  logic              fe_view,
    input  logic              decide,
    input  logic              bit_val,
    input  logic              bit_end,
    output logic              arm,
    output logic              run,
    output logic              acc,
    output logic [DATA_W-1:0] acc_data,
    output logic              acc_b9,
    output logic              acc_b9_we,
    output logic              fe_set
);
    localparam int IW = $clog2(DATA_W + 2);

    rx_state_e       st;
    logic [IW-1:0]   idx;
    logic [IW-1:0]   last_idx;
    logic [DATA_W:0] shreg;
    logic            rxd_prev;
    logic            nine;
    logic            dec_ninth;
    logic            dec_stop;
    logic            at_point;
    logic            b9_now;

    assign nine     = mode[1];
    assign last_idx = nine ? IW'(DATA_W) : IW'(DATA_W - 1);
    assign run      = (st != RX_IDLE);
    assign arm      = (st == RX_IDLE) && tick && rxd_prev && !rxd_s
                      && rx_en && (mode != 2'b00);

    // Line history for falling-edge detection, updated on enabled ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rxd_prev <= 1'b1;
        else if (tick)
            rxd_prev <= rxd_s;
    end

    // Frame state and bit index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= RX_IDLE;
            idx <= '0;
        end else begin
            case (st)
                RX_IDLE: begin
                    if (arm) begin
                        st  <= RX_START;
                        idx <= '0;
                    end
                end
                RX_START: begin
                    if (decide && bit_val)
                        st <= RX_IDLE;
                    else if (bit_end)
                        st <= RX_DATA;
                end
                RX_DATA: begin
                    if (bit_end) begin
                        if (idx == last_idx)
                            st <= RX_STOP;
                        else
                            idx <= idx + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (decide)
                        st <= RX_IDLE;
                end
                default: st <= RX_IDLE;
            endcase
        end
    end

    // Data bits land at their own index, least significant first.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shreg <= '0;
        else if ((st == RX_DATA) && decide)
            shreg[idx] <= bit_val;
    end

    // Acceptance point, address filter and stop check.
    assign dec_ninth = (st == RX_DATA) && decide && nine && (idx == IW'(DATA_W));
    assign dec_stop  = (st == RX_STOP) && decide;
    assign b9_now    = (st == RX_DATA) ? bit_val : shreg[DATA_W];
    assign at_point  = (nine && !fe_view) ? dec_ninth : dec_stop;
    assign acc       = at_point && !(nine && mp_en && !b9_now);
    assign acc_data  = shreg[DATA_W-1:0];
    assign acc_b9    = b9_now;
    assign acc_b9_we = acc && nine;
    assign fe_set    = dec_stop && !bit_val;

endmodule

// File: rtl/serrx_ctrl_regs.sv
// Control register, view bit, framing-error flag and receive buffer.
// Hardware set events take priority over software writes in the same cycle.
module serrx_ctrl_regs
    import serrx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              opt_we,
    input  logic              opt_wdata,
    input  logic              hw_acc,
    input  logic [DATA_W-1:0] hw_data,
    input  logic              hw_b9_we,
    input  logic              hw_b9,
    input  logic              hw_fe,
    output logic [1:0]        mode,
    output logic              mp_en,
    output logic              rx_en,
    output logic              view,
    output logic [CTRL_W-1:0] ctrl_rdata,
    output logic [DATA_W-1:0] rbuf
);
    ctrl_s             cr;
    ctrl_s             wr;
    logic              fe;
    logic [CTRL_W-1:0] cr_bits;

    assign wr      = ctrl_s'(ctrl_wdata);
    assign cr_bits = cr;

    // View-select bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            view <= 1'b0;
        else if (opt_we)
            view <= opt_wdata;
    end

    // Control fields; receive flag and ninth bit are overridden by hardware.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cr <= '0;
        end else begin
            if (ctrl_we) begin
                cr.mode_lo <= wr.mode_lo;
                cr.mp_en   <= wr.mp_en;
                cr.rx_en   <= wr.rx_en;
                cr.tx_b9   <= wr.tx_b9;
                cr.rx_b9   <= wr.rx_b9;
                cr.tx_done <= wr.tx_done;
                cr.rx_done <= wr.rx_done;
                if (!view)
                    cr.top <= wr.top;
            end
            if (hw_b9_we)
                cr.rx_b9 <= hw_b9;
            if (hw_acc)
                cr.rx_done <= 1'b1;
        end
    end

    // Sticky framing-error flag, cleared only by a write through the view.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fe <= 1'b0;
        else if (hw_fe)
            fe <= 1'b1;
        else if (ctrl_we && view)
            fe <= wr.top;
    end

    // Receive buffer, loaded only on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rbuf <= '0;
        else if (hw_acc)
            rbuf <= hw_data;
    end

    assign mode       = {cr.top, cr.mode_lo};
    assign mp_en      = cr.mp_en;
    assign rx_en      = cr.rx_en;
    assign ctrl_rdata = {view ? fe : cr_bits[7], cr_bits[6:0]};

endmodule

// File: rtl/serial_rx_fe.sv
// Top of the serial receiver: line synchroniser, bit sampler, frame
// sequencer and register block. Assumes baud_tick is a single-cycle enable.
module serial_rx_fe
    import serrx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OVS         = 16,
    parameter int MID         = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              rxd,
    input  logic              ctrl_we,
    input  logic [7:0]        ctrl_wdata,
    input  logic              opt_we,
    input  logic              opt_wdata,
    output logic [7:0]        ctrl_rdata,
    output logic              opt_rdata,
    output logic [DATA_W-1:0] rxbuf_rdata
);
    logic [SYNC_STAGES-1:0] sync;
    logic              rxd_s;
    logic              arm;
    logic              run;
    logic              decide;
    logic              bit_val;
    logic              bit_end;
    logic              acc;
    logic [DATA_W-1:0] acc_data;
    logic              acc_b9;
    logic              acc_b9_we;
    logic              fe_set;
    logic [1:0]        mode;
    logic              mp_en;
    logic              rx_en;
    logic              view;
    logic              mode_hi;

    // Bring the asynchronous line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sync <= '1;
        else
            sync <= {sync[SYNC_STAGES-2:0], rxd};
    end

    assign rxd_s     = sync[SYNC_STAGES-1];
    assign mode_hi   = mode[1];
    assign opt_rdata = view;

    serrx_sampler #(
        .OVS (OVS),
        .MID (MID)
    ) u_smp (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (baud_tick),
        .arm     (arm),
        .run     (run),
        .rxd_s   (rxd_s),
        .decide  (decide),
        .bit_val (bit_val),
        .bit_end (bit_end)
    );

    serrx_frame_fsm #(
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (baud_tick),
        .rxd_s     (rxd_s),
        .mode      (mode),
        .rx_en     (rx_en),
        .mp_en     (mp_en),
        .fe_view   (view),
        .decide    (decide),
        .bit_val   (bit_val),
        .bit_end   (bit_end),
        .arm       (arm),
        .run       (run),
        .acc       (acc),
        .acc_data  (acc_data),
        .acc_b9    (acc_b9),
        .acc_b9_we (acc_b9_we),
        .fe_set    (fe_set)
    );

    serrx_ctrl_regs #(
        .DATA_W (DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .opt_we     (opt_we),
        .opt_wdata  (opt_wdata),
        .hw_acc     (acc),
        .hw_data    (acc_data),
        .hw_b9_we   (acc_b9_we),
        .hw_b9      (acc_b9),
        .hw_fe      (fe_set),
        .mode       (mode),
        .mp_en      (mp_en),
        .rx_en      (rx_en),
        .view       (view),
        .ctrl_rdata (ctrl_rdata),
        .rbuf       (rxbuf_rdata)
    );

endmodule

// File: rtl/serial_rx_fe_chk.sv
// Property checker for the serial receiver, attached by bind.
module serial_rx_fe_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctrl_we,
    input logic              opt_we,
    input logic              opt_rdata,
    input logic [7:0]        ctrl_rdata,
    input logic [DATA_W-1:0] rxbuf_rdata,
    input logic              acc,
    input logic              arm,
    input logic              run,
    input logic              fe_set,
    input logic              mode_hi
);
    // R9
    fe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opt_rdata && ctrl_rdata[7] && !ctrl_we && !opt_we) |=> ctrl_rdata[7]);

    // R4
    buf_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rxbuf_rdata) |-> ctrl_rdata[0]);

    // R11
    flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> ctrl_rdata[0]);

    // R11
    fe_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_set && opt_rdata && !opt_we) |=> ctrl_rdata[7]);

    // R8
    arm_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> run);

    // R2
    mode_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && opt_rdata && !opt_we) |=> $stable(mode_hi));

endmodule

bind serial_rx_fe serial_rx_fe_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_we     (ctrl_we),
    .opt_we      (opt_we),
    .opt_rdata   (opt_rdata),
    .ctrl_rdata  (ctrl_rdata),
    .rxbuf_rdata (rxbuf_rdata),
    .acc         (acc),
    .arm         (arm),
    .run         (run),
    .fe_set      (fe_set),
    .mode_hi     (mode_hi)
);

// File: tb/serial_rx_fe_tb.sv
// Self-checking bench: sweeps frames in every mode and view, with expected
// values derived from the bit grid (sync depth 2, decision at tick 9).
module serial_rx_fe_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b1;
    logic       rxd = 1'b1;
    logic       ctrl_we = 1'b0;
    logic [7:0] ctrl_wdata = 8'h00;
    logic       opt_we = 1'b0;
    logic       opt_wdata = 1'b0;
    logic [7:0] ctrl_rdata;
    logic       opt_rdata;
    logic [7:0] rxbuf_rdata;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] exp_buf = 8'h00;

    always #10 clk = ~clk;

    serial_rx_fe u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .baud_tick   (baud_tick),
        .rxd         (rxd),
        .ctrl_we     (ctrl_we),
        .ctrl_wdata  (ctrl_wdata),
        .opt_we      (opt_we),
        .opt_wdata   (opt_wdata),
        .ctrl_rdata  (ctrl_rdata),
        .opt_rdata   (opt_rdata),
        .rxbuf_rdata (rxbuf_rdata)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        @(negedge clk);
        ctrl_we    = 1'b1;
        ctrl_wdata = v;
        @(negedge clk);
        ctrl_we    = 1'b0;
    endtask

    task automatic wr_opt(input logic v);
        @(negedge clk);
        opt_we    = 1'b1;
        opt_wdata = v;
        @(negedge clk);
        opt_we    = 1'b0;
    endtask

    // Drive one frame; cycle n of the loop feeds the edge that follows it.
    task automatic send_frame(input logic [8:0] d, input bit nine, input logic stopv,
                              input int div, input int gpos,
                              input int ca_n, input int ca_v,
                              input int cb_n, input int cb_v, input string tag,
                              input int wr_n, input logic [7:0] wr_val);
        int nb;
        nb = nine ? 11 : 10;
        for (int n = 0; n < 16 * nb * div; n++) begin
            int   bi;
            logic v;
            bi = (n / div) / 16;
            if (bi == 0)           v = 1'b0;
            else if (bi == nb - 1) v = stopv;
            else                   v = d[bi-1];
            @(negedge clk);
            rxd        = v ^ (n == gpos);
            baud_tick  = ((n % div) == 0);
            ctrl_we    = (n == wr_n);
            ctrl_wdata = wr_val;
            if (n == ca_n) check({tag, " flag before point"}, int'(ctrl_rdata[0]), ca_v);
            if (n == cb_n) check({tag, " flag at point"}, int'(ctrl_rdata[0]), cb_v);
        end
        @(negedge clk);
        rxd       = 1'b1;
        baud_tick = 1'b1;
        ctrl_we   = 1'b0;
        repeat (24) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ctrl", int'(ctrl_rdata), 8'h00);
        check("R1 view", int'(opt_rdata), 0);
        check("R1 buf", int'(rxbuf_rdata), 8'h00);

        // R2 bit 7 routing through the view
        wr_ctrl(8'h48);
        @(negedge clk);
        check("R2 plain write", int'(ctrl_rdata), 8'h48);
        wr_opt(1'b1);
        wr_ctrl(8'h80);
        @(negedge clk);
        check("R2 fe via view", int'(ctrl_rdata), 8'h80);
        wr_opt(1'b0);
        @(negedge clk);
        check("R2 mode bit kept", int'(ctrl_rdata), 8'h00);
        wr_opt(1'b1);
        @(negedge clk);
        check("R2 fe hidden then shown", int'(ctrl_rdata), 8'h80);
        wr_ctrl(8'h00);
        @(negedge clk);
        check("R2 R9 fe cleared", int'(ctrl_rdata), 8'h00);
        wr_opt(1'b0);

        // R3 receive disabled, then mode off
        wr_ctrl(8'h40);
        send_frame(9'h0A5, 1'b0, 1'b1, 1, -1, -1, 0, -1, 0, "", -1, 8'h00);
        check("R3 rx_en low ctrl", int'(ctrl_rdata), 8'h40);
        check("R3 rx_en low buf", int'(rxbuf_rdata), 8'h00);
        wr_ctrl(8'h10);
        send_frame(9'h05A, 1'b0, 1'b1, 1, -1, -1, 0, -1, 0, "", -1, 8'h00);
        check("R3 mode off ctrl", int'(ctrl_rdata), 8'h10);
        check("R3 mode off buf", int'(rxbuf_rdata), 8'h00);

        // R4 full 8-bit sweep, view clear, with flag timing
        wr_ctrl(8'h50);
        for (int d = 0; d < 256; d++) begin
            send_frame({1'b0, 8'(d)}, 1'b0, 1'b1, 1, -1, 150, 0, 160, 1, "R4", -1, 8'h00);
            check("R4 ctrl", int'(ctrl_rdata), 8'h51);
            check("R4 buf", int'(rxbuf_rdata), d);
            wr_ctrl(8'h50);
        end
        exp_buf = 8'hFF;

        // R4 ninth-bit field untouched in 8-bit mode, and view set
        wr_ctrl(8'h54);
        wr_opt(1'b1);
        send_frame(9'h03C, 1'b0, 1'b1, 1, -1, 150, 0, 160, 1, "R4 view", -1, 8'h00);
        check("R4 view ctrl", int'(ctrl_rdata), 8'h55);
        check("R4 view buf", int'(rxbuf_rdata), 8'h3C);
        wr_ctrl(8'h50);
        wr_opt(1'b0);

        // R12 slow enable, one tick every 3 clocks
        for (int k = 0; k < 3; k++) begin
            logic [7:0] dv;
            dv = (k == 0) ? 8'h81 : ((k == 1) ? 8'h7E : 8'h33);
            send_frame({1'b0, dv}, 1'b0, 1'b1, 3, -1, -1, 0, -1, 0, "", -1, 8'h00);
            check("R12 ctrl", int'(ctrl_rdata), 8'h51);
            check("R12 buf", int'(rxbuf_rdata), int'(dv));
            wr_ctrl(8'h50);
        end

        // R7 single deviating samples at ticks 8, 9 and 7
        send_frame(9'h0C5, 1'b0, 1'b1, 1, 16 * 1 + 8, -1, 0, -1, 0, "", -1, 8'h00);
        check("R7 glitch tick 8", int'(rxbuf_rdata), 8'hC5);
        wr_ctrl(8'h50);
        send_frame(9'h0C5, 1'b0, 1'b1, 1, 16 * 4 + 9, -1, 0, -1, 0, "", -1, 8'h00);
        check("R7 glitch tick 9", int'(rxbuf_rdata), 8'hC5);
        wr_ctrl(8'h50);
        send_frame(9'h0C5, 1'b0, 1'b1, 1, 16 * 8 + 7, -1, 0, -1, 0, "", -1, 8'h00);
        check("R7 glitch tick 7", int'(rxbuf_rdata), 8'hC5);
        wr_ctrl(8'h50);

        // R8 false start: low for 6 ticks only
        for (int n = 0; n < 40; n++) begin
            @(negedge clk);
            rxd = (n < 6) ? 1'b0 : 1'b1;
        end
        repeat (200) @(negedge clk);
        check("R8 no flag", int'(ctrl_rdata), 8'h50);
        check("R8 buf kept", int'(rxbuf_rdata), 8'hC5);
        send_frame(9'h096, 1'b0, 1'b1, 1, -1, -1, 0, -1, 0, "", -1, 8'h00);
        check("R8 next frame", int'(rxbuf_rdata), 8'h96);
        wr_ctrl(8'h50);

        // R5 9-bit sweep, view clear: accept at ninth bit
        wr_ctrl(8'h90);
        for (int i = 0; i < 52; i++) begin
            for (int b = 0; b < 2; b++) begin
                send_frame({1'(b), 8'(i * 5)}, 1'b1, 1'b1, 1, -1, 150, 0, 160, 1, "R5", -1, 8'h00);
                check("R5 ctrl", int'(ctrl_rdata), 8'h91 | (b << 2));
                check("R5 buf", int'(rxbuf_rdata), i * 5);
                wr_ctrl(8'h90);
            end
        end
        wr_ctrl(8'hD0);
        send_frame(9'h1E7, 1'b1, 1'b1, 1, -1, 150, 0, 160, 1, "R5 mode11", -1, 8'h00);
        check("R5 mode11 ctrl", int'(ctrl_rdata), 8'hD5);
        check("R5 mode11 buf", int'(rxbuf_rdata), 8'hE7);

        // R6 9-bit, view set: accept at stop bit
        wr_ctrl(8'h90);
        wr_opt(1'b1);
        for (int i = 0; i < 16; i++) begin
            send_frame({1'(i & 1), 8'(i * 17)}, 1'b1, 1'b1, 1, -1, 165, 0, 175, 1, "R6", -1, 8'h00);
            check("R6 ctrl", int'(ctrl_rdata), 8'h11 | ((i & 1) << 2));
            check("R6 buf", int'(rxbuf_rdata), i * 17);
            wr_ctrl(8'h10);
        end

        // R9 framing error in 9-bit mode, visible through the view
        check("R9 pre", int'(ctrl_rdata), 8'h10);
        send_frame(9'h1A5, 1'b1, 1'b0, 1, -1, -1, 0, -1, 0, "", -1, 8'h00);
        check("R9 set 9-bit", int'(ctrl_rdata), 8'h95);
        wr_ctrl(8'h10);
        wr_opt(1'b0);

        // R9 sticky in 8-bit mode
        wr_ctrl(8'h50);
        wr_opt(1'b1);
        send_frame(9'h011, 1'b0, 1'b0, 1, -1, -1, 0, -1, 0, "", -1, 8'h00);
        check("R9 set 8-bit", int'(ctrl_rdata), 8'hD1);
        wr_ctrl(8'hD0);
        send_frame(9'h022, 1'b0, 1'b1, 1, -1, -1, 0, -1, 0, "", -1, 8'h00);
        check("R9 kept by good stop", int'(ctrl_rdata), 8'hD1);
        wr_ctrl(8'h50);
        @(negedge clk);
        check("R9 cleared by write", int'(ctrl_rdata), 8'h50);

        // R11 write of 0 on the exact decision edge of a bad stop bit
        send_frame(9'h03C, 1'b0, 1'b0, 1, -1, -1, 0, -1, 0, "", 155, 8'h50);
        check("R11 set wins", int'(ctrl_rdata), 8'hD1);
        wr_ctrl(8'h50);
        @(negedge clk);
        check("R11 later write clears", int'(ctrl_rdata), 8'h50);
        wr_opt(1'b0);

        // R10 address filter
        wr_ctrl(8'hB0);
        send_frame(9'h066, 1'b1, 1'b1, 1, -1, -1, 0, -1, 0, "", -1, 8'h00);
        check("R10 dropped ctrl", int'(ctrl_rdata), 8'hB0);
        check("R10 dropped buf", int'(rxbuf_rdata), 8'h3C);
        send_frame(9'h199, 1'b1, 1'b1, 1, -1, -1, 0, -1, 0, "", -1, 8'h00);
        check("R10 accepted ctrl", int'(ctrl_rdata), 8'hB5);
        check("R10 accepted buf", int'(rxbuf_rdata), 8'h99);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule